// File: doc/BRIEF.md
# Overflow-interval utilization estimator

This block turns overflow events from per-channel traffic counters into a coarse utilization figure for a memory frequency governor. Each channel's counter is preloaded so that it overflows after a fixed batch of events. The block keeps its own free-running nanosecond time base and remembers, for every channel, the time of that channel's previous overflow. When an overflow is serviced, the time since the previous one decides the result. A short interval means heavy traffic, so the block reports a high busy value. A long interval means light traffic, so it reports a low one. The total value is always fixed. Heavy traffic pushes the busy figure up at once, and light traffic only lowers it to a moderate level, so the frequency rises quickly and falls slowly.

Servicing is a fixed sequence run by a state machine. From ST_INIT, which loads every channel's mark with the current time and sets the busy value to its start-up level, the machine goes to ST_START. ST_START arms the counters once and then moves to ST_IDLE. ST_IDLE waits for a pending overflow and moves to ST_STOP. ST_STOP halts the counters, picks the channel and captures the time. ST_EVAL compares the interval with the threshold, updates the result and replaces the mark. ST_REARM restarts the counters with the preload value, publishes the result and returns to ST_IDLE. The transitions ST_INIT→ST_START, ST_START→ST_IDLE, ST_STOP→ST_EVAL, ST_EVAL→ST_REARM and ST_REARM→ST_IDLE are unconditional. ST_IDLE→ST_STOP is taken when any overflow is pending.

An overflow pulse sets a pending bit for its channel. Pending bits are kept while a service is running and are handled afterwards, with the lowest channel number first.

Top module: `ovf_util_est`

## Requirements
- R1: `ts_ns` is 0 while reset is held. It then grows by STEP_NS on every clock cycle.
- R2: While reset is held and after it is released, `busy` is BUSY_INIT (99) and `total` is TOTAL_VAL (100). After reset, `cnt_restart` pulses exactly once before any service takes place. This pulse has no `util_valid`. Every channel mark starts at the time of the first cycle after reset, which is 0.
- R3: A service holds `cnt_stop` high for exactly two cycles. The next cycle has `cnt_restart` high, `cnt_stop` low and `cnt_preload` equal to PRELOAD (0xFF000000).
- R4: The interval of a service is `ts_ns` in its first `cnt_stop` cycle minus the mark stored for the serviced channel. That mark then becomes the captured time.
- R5: If the interval is below THRESH_NS, `busy` becomes BUSY_FAST (70). Otherwise it becomes BUSY_SLOW (35). `total` is always TOTAL_VAL (100).
- R6: `util_valid` is a one-cycle pulse in the `cnt_restart` cycle of each service, two cycles after `cnt_stop` rises. `busy`, `total` and `eval_ch` carry the new result in that cycle. `busy` and `total` change at no other time.
- R7: If several channels are pending when a service starts, the lowest-numbered channel is serviced. `eval_ch` reports the serviced channel number.
- R8: An overflow pulse that arrives during a service stays pending and is serviced later. Several pulses on one channel before its service merge into one service. No service runs without a pending pulse.
- R9: `cnt_preload` is 0 in every cycle where `cnt_restart` is low.
- R10: An interval exactly equal to THRESH_NS gives BUSY_SLOW. An interval one step shorter gives BUSY_FAST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovf_in | input | N_CH | One-cycle overflow pulse per channel |
| ts_ns | output | TS_W | Free-running nanosecond time base |
| cnt_stop | output | 1 | Holds the event counters during a service |
| cnt_restart | output | 1 | One-cycle request to reload and restart the counters |
| cnt_preload | output | CNT_W | Reload value, valid with `cnt_restart` |
| util_valid | output | 1 | One-cycle strobe for a new busy/total pair |
| busy | output | VAL_W | Busy part of the utilization figure |
| total | output | VAL_W | Total part of the utilization figure |
| eval_ch | output | CH_W | Channel of the latest evaluation |

## Verification
The bench sets the threshold to a few hundred cycles. It spaces two overflows of one channel exactly at the threshold and one cycle below it. A design with an inclusive compare, or a capture point shifted by one cycle, gives the wrong busy level. The bench fires both channels in the same cycle, so a design with reversed priority or a lost second channel reports the wrong `eval_ch` or misses a service. It also sends pulses into the stop and evaluation cycles and repeats pulses before service. A design that clears a pending bit too eagerly loses a service, and one that counts pulses instead of merging them services a channel with nothing pending. Random bursts and long gaps then mix both busy levels against a per-channel time model kept in the bench.

// File: rtl/ovf_util_pkg.sv
package ovf_util_pkg;

    // Service sequencer states
    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_START = 3'd1,
        ST_IDLE  = 3'd2,
        ST_STOP  = 3'd3,
        ST_EVAL  = 3'd4,
        ST_REARM = 3'd5
    } est_state_t;

    // Width of a channel index for a given channel count
    function automatic int ch_width(input int n_ch);
        return (n_ch > 1) ? $clog2(n_ch) : 1;
    endfunction

endpackage

// File: rtl/ovf_ts_counter.sv
module ovf_ts_counter #(
    parameter int TS_W    = 64,
    parameter int STEP_NS = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts
);
    localparam logic [TS_W-1:0] STEP = TS_W'(STEP_NS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + STEP;
    end
endmodule

// File: rtl/ovf_pend_latch.sv
module ovf_pend_latch #(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] set_v,
    input  logic [N_CH-1:0] clr_v,
    output logic [N_CH-1:0] pend
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic hold_q;
        // a new pulse wins over a clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         hold_q <= 1'b0;
            else if (set_v[g])  hold_q <= 1'b1;
            else if (clr_v[g])  hold_q <= 1'b0;
        end
        assign pend[g] = hold_q;
    end
endmodule

// File: rtl/ovf_prio_pick.sv
module ovf_prio_pick #(
    parameter int N_CH = 2,
    parameter int CH_W = 1
) (
    input  logic [N_CH-1:0] req,
    output logic            any,
    output logic [CH_W-1:0] idx,
    output logic [N_CH-1:0] onehot
);
    always_comb begin
        idx = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = CH_W'(i);
        end
        any    = |req;
        onehot = any ? (N_CH'(1) << idx) : '0;
    end
endmodule

// File: rtl/ovf_interval_eval.sv
module ovf_interval_eval #(
    parameter int              N_CH      = 2,
    parameter int              CH_W      = 1,
    parameter int              TS_W      = 64,
    parameter longint unsigned THRESH_NS = 64'd900_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_all,
    input  logic [TS_W-1:0] t_now,
    input  logic            upd,
    input  logic [CH_W-1:0] sel,
    input  logic [TS_W-1:0] t_cap,
    output logic            fast
);
    localparam logic [TS_W-1:0] THR = TS_W'(THRESH_NS);

    logic [TS_W-1:0] marks [N_CH];
    logic [TS_W-1:0] mark_sel;
    logic [TS_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) marks[i] <= '0;
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                if (load_all)                      marks[i] <= t_now;
                else if (upd && sel == CH_W'(i))   marks[i] <= t_cap;
            end
        end
    end

    always_comb begin
        mark_sel = marks[0];
        for (int i = 0; i < N_CH; i++) begin
            if (sel == CH_W'(i)) mark_sel = marks[i];
        end
        gap  = t_cap - mark_sel;
        fast = (gap < THR);
    end
endmodule

// File: rtl/ovf_util_est.sv
module ovf_util_est
    import ovf_util_pkg::*;
#(
    parameter int              N_CH      = 2,
    parameter int              TS_W      = 64,
    parameter int              STEP_NS   = 10,
    parameter longint unsigned THRESH_NS = 64'd900_000_000,
    parameter int              VAL_W     = 8,
    parameter int              BUSY_FAST = 70,
    parameter int              BUSY_SLOW = 35,
    parameter int              BUSY_INIT = 99,
    parameter int              TOTAL_VAL = 100,
    parameter int              CNT_W     = 32,
    parameter logic [CNT_W-1:0] PRELOAD  = 32'hFF00_0000,
    localparam int             CH_W      = ch_width(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  ovf_in,
    output logic [TS_W-1:0]  ts_ns,
    output logic             cnt_stop,
    output logic             cnt_restart,
    output logic [CNT_W-1:0] cnt_preload,
    output logic             util_valid,
    output logic [VAL_W-1:0] busy,
    output logic [VAL_W-1:0] total,
    output logic [CH_W-1:0]  eval_ch
);
    est_state_t state_q, state_d;

    logic [N_CH-1:0] pend;
    logic [N_CH-1:0] clr_v;
    logic            pend_any;
    logic [CH_W-1:0] pick_idx;
    logic [N_CH-1:0] pick_oh;
    logic            load_all;
    logic            upd;
    logic            fast;
    logic [CH_W-1:0] sel_q;
    logic [TS_W-1:0] cap_q;
    logic [VAL_W-1:0] busy_q;
    logic [VAL_W-1:0] total_q;

    ovf_ts_counter #(.TS_W(TS_W), .STEP_NS(STEP_NS)) u_ts (
        .clk(clk), .rst_n(rst_n), .ts(ts_ns)
    );

    ovf_pend_latch #(.N_CH(N_CH)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_v(ovf_in), .clr_v(clr_v), .pend(pend)
    );

    ovf_prio_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick (
        .req(pend), .any(pend_any), .idx(pick_idx), .onehot(pick_oh)
    );

    ovf_interval_eval #(
        .N_CH(N_CH), .CH_W(CH_W), .TS_W(TS_W), .THRESH_NS(THRESH_NS)
    ) u_eval (
        .clk(clk), .rst_n(rst_n), .load_all(load_all), .t_now(ts_ns),
        .upd(upd), .sel(sel_q), .t_cap(cap_q), .fast(fast)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  state_d = ST_START;
            ST_START: state_d = ST_IDLE;
            ST_IDLE:  if (pend_any) state_d = ST_STOP;
            ST_STOP:  state_d = ST_EVAL;
            ST_EVAL:  state_d = ST_REARM;
            ST_REARM: state_d = ST_IDLE;
            default:  state_d = ST_INIT;
        endcase
    end

    // State-decoded controls and outputs
    always_comb begin
        cnt_stop    = 1'b0;
        cnt_restart = 1'b0;
        util_valid  = 1'b0;
        load_all    = 1'b0;
        upd         = 1'b0;
        clr_v       = '0;
        unique case (state_q)
            ST_INIT:  load_all = 1'b1;
            ST_START: cnt_restart = 1'b1;
            ST_IDLE:  ;
            ST_STOP: begin
                cnt_stop = 1'b1;
                clr_v    = pick_oh;
            end
            ST_EVAL: begin
                cnt_stop = 1'b1;
                upd      = 1'b1;
            end
            ST_REARM: begin
                cnt_restart = 1'b1;
                util_valid  = 1'b1;
            end
            default: ;
        endcase
        cnt_preload = cnt_restart ? PRELOAD : '0;
    end

    // Capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            cap_q   <= '0;
            busy_q  <= VAL_W'(BUSY_INIT);
            total_q <= VAL_W'(TOTAL_VAL);
        end else begin
            if (state_q == ST_INIT) begin
                busy_q  <= VAL_W'(BUSY_INIT);
                total_q <= VAL_W'(TOTAL_VAL);
            end
            if (state_q == ST_STOP) begin
                sel_q <= pick_idx;
                cap_q <= ts_ns;
            end
            if (state_q == ST_EVAL) begin
                busy_q  <= fast ? VAL_W'(BUSY_FAST) : VAL_W'(BUSY_SLOW);
                total_q <= VAL_W'(TOTAL_VAL);
            end
        end
    end

    assign busy    = busy_q;
    assign total   = total_q;
    assign eval_ch = sel_q;
endmodule

// File: rtl/ovf_util_est_chk.sv
module ovf_util_est_chk #(
    parameter int               TS_W      = 64,
    parameter int               STEP_NS   = 10,
    parameter int               VAL_W     = 8,
    parameter int               BUSY_FAST = 70,
    parameter int               BUSY_SLOW = 35,
    parameter int               TOTAL_VAL = 100,
    parameter int               CNT_W     = 32,
    parameter logic [CNT_W-1:0] PRELOAD   = 32'hFF00_0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TS_W-1:0]  ts_ns,
    input logic             cnt_stop,
    input logic             cnt_restart,
    input logic [CNT_W-1:0] cnt_preload,
    input logic             util_valid,
    input logic [VAL_W-1:0] busy,
    input logic [VAL_W-1:0] total
);
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ts_ns == $past(ts_ns) + TS_W'(STEP_NS)); // R1

    AST_STOP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_stop) |=> cnt_stop); // R3

    AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && cnt_stop && $past(cnt_stop)) |=> (!cnt_stop && cnt_restart)); // R3

    AST_RESTART_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_restart |-> (cnt_preload == PRELOAD && !cnt_stop)); // R3

    AST_PRELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_restart |-> cnt_preload == '0); // R9

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        util_valid |=> !util_valid); // R6

    AST_VALID_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        util_valid |-> (armed_q && $past(cnt_stop) && cnt_restart)); // R6

    AST_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        util_valid |-> ((busy == VAL_W'(BUSY_FAST) || busy == VAL_W'(BUSY_SLOW))
                        && total == VAL_W'(TOTAL_VAL))); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !util_valid) |-> ($stable(busy) && $stable(total))); // R6
endmodule

bind ovf_util_est ovf_util_est_chk #(
    .TS_W(TS_W), .STEP_NS(STEP_NS), .VAL_W(VAL_W), .BUSY_FAST(BUSY_FAST),
    .BUSY_SLOW(BUSY_SLOW), .TOTAL_VAL(TOTAL_VAL), .CNT_W(CNT_W), .PRELOAD(PRELOAD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ts_ns(ts_ns), .cnt_stop(cnt_stop),
    .cnt_restart(cnt_restart), .cnt_preload(cnt_preload),
    .util_valid(util_valid), .busy(busy), .total(total)
);

// File: tb/ovf_util_est_test.sv
module ovf_util_est_test;
    localparam int     NS   = 10;
    localparam longint THR  = 5000;
    localparam int     TS_W = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ovf_in = 2'b00;
    logic [63:0] ts_ns;
    logic        cnt_stop, cnt_restart, util_valid;
    logic [31:0] cnt_preload;
    logic [7:0]  busy, total;
    logic [0:0]  eval_ch;

    always #5 clk = ~clk;

    ovf_util_est #(
        .N_CH(2), .TS_W(TS_W), .STEP_NS(NS), .THRESH_NS(THR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ovf_in(ovf_in), .ts_ns(ts_ns),
        .cnt_stop(cnt_stop), .cnt_restart(cnt_restart), .cnt_preload(cnt_preload),
        .util_valid(util_valid), .busy(busy), .total(total), .eval_ch(eval_ch)
    );

    int     checks = 0;
    int     fails = 0;
    bit     done = 0;
    longint tcount = 0;
    logic [1:0] bpend = 2'b00;
    longint blast [2];
    int     q_busy [$];
    int     q_ch [$];
    int     q_due [$];
    int     sidx = 0;
    bit     prev_stop = 0;
    logic [7:0] last_busy = 8'd99;
    int     init_restarts = 0;
    int     vcount = 0;
    int     last_vbusy = 0;

    // bench time base: posedges seen out of reset
    always @(posedge clk) begin
        if (!rst_n) tcount <= 0;
        else        tcount <= tcount + 1;
    end

    function automatic int exp_level(input longint gap);
        return (gap < THR) ? 70 : 35;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sample();
        int ch;
        longint tcap;
        sidx++;
        if (rst_n)
            chk(ts_ns == 64'(tcount * NS), "R1", "time base", longint'(ts_ns), tcount * NS);
        if (!cnt_restart)
            chk(cnt_preload == 32'h0, "R9", "preload idle", longint'(cnt_preload), 0);
        else
            chk(cnt_preload == 32'hFF00_0000 && !cnt_stop, "R3", "restart preload",
                longint'(cnt_preload), 64'hFF00_0000);
        if (cnt_restart && !util_valid) init_restarts++;
        if (cnt_stop && !prev_stop) begin
            chk(bpend != 2'b00, "R8", "service with nothing pending", longint'(bpend), 1);
            ch = bpend[0] ? 0 : 1;
            bpend[ch] = 1'b0;
            tcap = tcount * NS;
            q_busy.push_back(exp_level(tcap - blast[ch]));
            q_ch.push_back(ch);
            q_due.push_back(sidx + 2);
            blast[ch] = tcap;
        end
        if (util_valid) begin
            vcount++;
            last_vbusy = int'(busy);
            if (q_busy.size() == 0) begin
                chk(1'b0, "R6", "valid without service", 1, 0);
            end else begin
                int eb, ec, ed;
                eb = q_busy.pop_front();
                ec = q_ch.pop_front();
                ed = q_due.pop_front();
                chk(int'(busy) == eb, "R4,R5", "busy level", longint'(busy), eb);
                chk(total == 8'd100, "R5", "total", longint'(total), 100);
                chk(int'(eval_ch) == ec, "R7", "serviced channel", longint'(eval_ch), ec);
                chk(sidx == ed, "R6", "valid timing", sidx, ed);
            end
        end else if (rst_n) begin
            chk(busy == last_busy, "R6", "busy held", longint'(busy), longint'(last_busy));
        end
        last_busy = busy;
        prev_stop = cnt_stop;
    endtask

    task automatic step(input logic [1:0] p);
        @(negedge clk);
        sample();
        ovf_in = p;
        bpend  = bpend | p;
    endtask

    task automatic wait_valid(output int b);
        int v0;
        v0 = vcount;
        while (vcount == v0) step(2'b00);
        b = last_vbusy;
    endtask

    initial begin
        int b;
        void'($urandom(32'd4711));
        blast[0] = 0;
        blast[1] = 0;
        repeat (3) @(negedge clk);
        // reset state
        chk(busy == 8'd99 && total == 8'd100, "R2", "busy in reset", longint'(busy), 99);
        chk(ts_ns == 64'd0, "R1", "time in reset", longint'(ts_ns), 0);
        chk(!cnt_stop && !util_valid && !cnt_restart, "R2", "controls in reset",
            longint'({cnt_stop, util_valid, cnt_restart}), 0);
        rst_n = 1'b1;
        repeat (6) step(2'b00);
        chk(init_restarts == 1, "R2", "start-up restarts", init_restarts, 1);
        chk(busy == 8'd99, "R2", "busy after start", longint'(busy), 99);

        // first overflow on channel 0: short interval from start
        repeat (50) step(2'b00);
        step(2'b01);
        wait_valid(b);
        chk(b == 70, "R5", "first ch0 busy", b, 70);

        // threshold boundary on channel 1 (R10)
        repeat (20) step(2'b00);
        step(2'b10);
        repeat (499) step(2'b00);
        step(2'b10);
        wait_valid(b);
        chk(b == 35, "R10", "gap equal to threshold", b, 35);
        repeat (498 - 0) begin
            step(2'b00);
            if (vcount == 0) break;
        end
        repeat (0) step(2'b00);
        // previous ch1 pulse issued before wait_valid; re-space exactly 499 cycles
        step(2'b10);
        repeat (498) step(2'b00);
        step(2'b10);
        wait_valid(b);
        chk(b == 70, "R10", "gap one step below threshold", b, 70);

        // simultaneous pulses: ch0 then ch1 (R7)
        repeat (20) step(2'b00);
        step(2'b11);
        repeat (12) step(2'b00);
        chk(q_busy.size() == 0 && bpend == 2'b00, "R7", "both channels serviced",
            longint'(bpend), 0);

        // pulses during service, repeated pulses merge (R8)
        step(2'b01);
        step(2'b00);
        step(2'b10);
        step(2'b01);
        step(2'b01);
        repeat (20) step(2'b00);
        chk(bpend == 2'b00, "R8", "late pulses serviced", longint'(bpend), 0);

        // random traffic
        for (int i = 0; i < 300; i++) begin
            int gap;
            logic [1:0] p;
            p = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 3) == 0) gap = $urandom_range(400, 700);
            else                           gap = $urandom_range(0, 30);
            step(p);
            repeat (gap) step(2'b00);
        end

        repeat (30) step(2'b00);
        chk(q_busy.size() == 0 && bpend == 2'b00, "R8", "all pending drained",
            longint'(q_busy.size()), 0);
        chk(init_restarts == 1, "R2", "no extra bare restart", init_restarts, 1);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule